// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit RISC core fetches next, and whether a control transfer also writes a return address. Each cycle it takes the current program counter, the fetched instruction word and the two source register values read for that instruction. It returns the following program counter and a link request: an enable, the destination register index and the value to write.

Sequential flow advances by four bytes. Two-register equality branches and single-register sign and zero tests add a sign-extended word offset to PC+4. Absolute jumps keep the top four bits of PC+4 and replace the rest with the 26-bit target field followed by two zero bits. The register jump copies a register value into the PC unchanged. The call forms raise the link request with PC+4 aimed at register 31. The two linking zero-compare branches raise it whether or not the branch is taken.

All four outputs are registered, so a result appears one clock after its inputs. An active-high synchronous reset loads a parameterised start address.

Top module: `nxpc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `next_pc_o` becomes RESET_PC (default 0x0000_1000), `link_en_o` becomes 0, and `link_idx_o` and `link_val_o` become 0.
- R2: An instruction that is not a control transfer gives `next_pc_o` = `pc_i`+4 and `link_en_o` = 0. This covers every opcode (bits 31:26) outside 0 to 7, opcode 0 with funct (bits 5:0) other than 8, and opcode 1 with rt field (bits 20:16) other than 0, 1, 16 or 17.
- R3: Opcode 4 is taken when `rs_val_i` equals `rt_val_i`, and opcode 5 is taken when they differ. A taken branch goes to `pc_i`+4 + (sign-extended bits 15:0 shifted left by 2). A branch that is not taken goes to `pc_i`+4.
- R4: The zero tests compare `rs_val_i` as a signed value. Opcode 6 is taken when it is <= 0 and opcode 7 when it is > 0. Opcode 1 with rt field 0 is taken when it is < 0, and with rt field 1 when it is >= 0. The target is the same as in R3.
- R5: Opcode 1 with rt field 16 (less than zero) or rt field 17 (greater or equal zero) branches as in R4. It always sets `link_en_o` = 1, `link_idx_o` = 31 and `link_val_o` = `pc_i`+4, taken or not.
- R6: Opcode 2 gives `next_pc_o` = {(`pc_i`+4)[31:28], instruction bits 25:0, 2'b00}, with no link.
- R7: Opcode 3 jumps to the same target as R6 and sets `link_en_o` = 1, `link_idx_o` = 31 and `link_val_o` = `pc_i`+4.
- R8: Opcode 0 with funct 8 gives `next_pc_o` = `rs_val_i` exactly, including its two low bits, with no link.
- R9: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge. Whenever `link_en_o` is 0, `link_idx_o` and `link_val_o` are 0.
- R10: All PC arithmetic wraps modulo 2^32, and negative offsets move the target backward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of the register named by bits 25:21 |
| rt_val_i | input | 32 | Value of the register named by bits 20:16 |
| next_pc_o | output | 32 | Registered next fetch address |
| link_en_o | output | 1 | Registered request to write a return address |
| link_idx_o | output | 5 | Registered link destination register index |
| link_val_o | output | 32 | Registered return address |

## Verification
Random instruction words are drawn mostly from the eight control opcodes, and the linking and non-linking rt codes are mixed under the compare-to-zero opcode. This shows whether each decode path picks the right target and link request rather than falling back to PC+4. Register values are forced equal, zero, most-negative or small positive part of the time. These cases split equality from inequality and the <= / < / >= / > tests at their edges, which random 32-bit values almost never reach. Directed words cover the following:
- a backward offset and PC wrap at the top of the address space, which separate signed from unsigned offset handling;
- a jump from a PC in a high 256 MB region, which shows where the upper bits come from;
- an unaligned register jump;
- a not-taken linking branch, which proves the link write is independent of the branch decision.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

    localparam int XW     = 32;
    localparam int RIDX_W = 5;
    localparam int OP_W   = 6;
    localparam int IMM_W  = 16;
    localparam int TGT_W  = 26;
    localparam int SEG_W  = XW - TGT_W - 2;

    // Opcode and sub-field codes that the fetch stage depends on
    localparam logic [OP_W-1:0]   OPC_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0]   OPC_REGIMM  = 6'd1;
    localparam logic [OP_W-1:0]   OPC_JMP     = 6'd2;
    localparam logic [OP_W-1:0]   OPC_CALL    = 6'd3;
    localparam logic [OP_W-1:0]   OPC_EQ      = 6'd4;
    localparam logic [OP_W-1:0]   OPC_NE      = 6'd5;
    localparam logic [OP_W-1:0]   OPC_LEZ     = 6'd6;
    localparam logic [OP_W-1:0]   OPC_GTZ     = 6'd7;
    localparam logic [5:0]        FN_REGJMP   = 6'd8;
    localparam logic [RIDX_W-1:0] RI_LTZ      = 5'd0;
    localparam logic [RIDX_W-1:0] RI_GEZ      = 5'd1;
    localparam logic [RIDX_W-1:0] RI_LTZ_LNK  = 5'd16;
    localparam logic [RIDX_W-1:0] RI_GEZ_LNK  = 5'd17;

    typedef enum logic [3:0] {
        K_SEQ,
        K_EQ,
        K_NE,
        K_LEZ,
        K_GTZ,
        K_LTZ,
        K_GEZ,
        K_JABS,
        K_JREG
    } flow_kind_e;

    typedef struct packed {
        flow_kind_e        kind;
        logic              link;
        logic [IMM_W-1:0]  imm;
        logic [TGT_W-1:0]  tgt;
    } flow_dec_t;

    function automatic logic [XW-1:0] word_offset(input logic [IMM_W-1:0] imm);
        return {{(XW-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
    endfunction

    function automatic logic [XW-1:0] seg_target(input logic [XW-1:0] pc4,
                                                 input logic [TGT_W-1:0] tgt);
        return {pc4[XW-1 -: SEG_W], tgt, 2'b00};
    endfunction

    function automatic logic is_branch(input flow_kind_e k);
        return (k == K_EQ) || (k == K_NE) || (k == K_LEZ) ||
               (k == K_GTZ) || (k == K_LTZ) || (k == K_GEZ);
    endfunction

endpackage

// File: rtl/nxpc_decode.sv
module nxpc_decode
    import nxpc_pkg::*;
(
    input  logic [XW-1:0] instr,
    output flow_dec_t     dec
);
    logic [OP_W-1:0]   opc;
    logic [RIDX_W-1:0] rt_fld;
    logic [5:0]        funct;

    assign opc    = instr[XW-1 -: OP_W];
    assign rt_fld = instr[20:16];
    assign funct  = instr[5:0];

    always_comb begin
        dec.kind = K_SEQ;
        dec.link = 1'b0;
        dec.imm  = instr[IMM_W-1:0];
        dec.tgt  = instr[TGT_W-1:0];
        unique case (opc)
            OPC_SPECIAL: if (funct == FN_REGJMP) dec.kind = K_JREG;
            OPC_REGIMM: begin
                unique case (rt_fld)
                    RI_LTZ:     dec.kind = K_LTZ;
                    RI_GEZ:     dec.kind = K_GEZ;
                    RI_LTZ_LNK: begin dec.kind = K_LTZ; dec.link = 1'b1; end
                    RI_GEZ_LNK: begin dec.kind = K_GEZ; dec.link = 1'b1; end
                    default:    dec.kind = K_SEQ;
                endcase
            end
            OPC_JMP:  dec.kind = K_JABS;
            OPC_CALL: begin dec.kind = K_JABS; dec.link = 1'b1; end
            OPC_EQ:   dec.kind = K_EQ;
            OPC_NE:   dec.kind = K_NE;
            OPC_LEZ:  dec.kind = K_LEZ;
            OPC_GTZ:  dec.kind = K_GTZ;
            default:  dec.kind = K_SEQ;
        endcase
    end
endmodule

// File: rtl/nxpc_cond.sv
module nxpc_cond
    import nxpc_pkg::*;
(
    input  flow_kind_e    kind,
    input  logic [XW-1:0] rs_val,
    input  logic [XW-1:0] rt_val,
    output logic          taken
);
    logic same;
    logic neg;
    logic zero;

    assign same = (rs_val == rt_val);
    assign neg  = rs_val[XW-1];
    assign zero = (rs_val == '0);

    always_comb begin
        unique case (kind)
            K_EQ:    taken = same;
            K_NE:    taken = !same;
            K_LEZ:   taken = neg || zero;
            K_GTZ:   taken = !neg && !zero;
            K_LTZ:   taken = neg;
            K_GEZ:   taken = !neg;
            K_JABS,
            K_JREG:  taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/nxpc_target.sv
module nxpc_target
    import nxpc_pkg::*;
(
    input  logic [XW-1:0] pc,
    input  flow_dec_t     dec,
    input  logic [XW-1:0] rs_val,
    input  logic          taken,
    output logic [XW-1:0] next_pc,
    output logic [XW-1:0] ret_addr
);
    logic [XW-1:0] pc4;
    logic [XW-1:0] rel_tgt;
    logic [XW-1:0] abs_tgt;

    assign pc4      = pc + XW'(4);
    assign rel_tgt  = pc4 + word_offset(dec.imm);
    assign abs_tgt  = seg_target(pc4, dec.tgt);
    assign ret_addr = pc4;

    always_comb begin
        next_pc = pc4;
        if (taken) begin
            if (dec.kind == K_JREG)      next_pc = rs_val;
            else if (dec.kind == K_JABS) next_pc = abs_tgt;
            else if (is_branch(dec.kind)) next_pc = rel_tgt;
        end
    end
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
    import nxpc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_1000,
    parameter logic [4:0]  LINK_IDX = 5'd31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] pc_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic [31:0] next_pc_o,
    output logic        link_en_o,
    output logic [4:0]  link_idx_o,
    output logic [31:0] link_val_o
);
    flow_dec_t     dec;
    logic          taken;
    logic [XW-1:0] npc_d;
    logic [XW-1:0] ret_d;

    nxpc_decode u_decode (
        .instr (instr_i),
        .dec   (dec)
    );

    nxpc_cond u_cond (
        .kind   (dec.kind),
        .rs_val (rs_val_i),
        .rt_val (rt_val_i),
        .taken  (taken)
    );

    nxpc_target u_target (
        .pc       (pc_i),
        .dec      (dec),
        .rs_val   (rs_val_i),
        .taken    (taken),
        .next_pc  (npc_d),
        .ret_addr (ret_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc_o  <= RESET_PC;
            link_en_o  <= 1'b0;
            link_idx_o <= '0;
            link_val_o <= '0;
        end else begin
            next_pc_o  <= npc_d;
            link_en_o  <= dec.link;
            link_idx_o <= dec.link ? LINK_IDX : '0;
            link_val_o <= dec.link ? ret_d : '0;
        end
    end
endmodule

// File: rtl/nxpc_unit_chk.sv
module nxpc_unit_chk #(
    parameter logic [31:0] RESET_PC = 32'h0000_1000,
    parameter logic [4:0]  LINK_IDX = 5'd31
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_i,
    input logic [31:0] instr_i,
    input logic [31:0] rs_val_i,
    input logic [31:0] rt_val_i,
    input logic [31:0] next_pc_o,
    input logic        link_en_o,
    input logic [4:0]  link_idx_o,
    input logic [31:0] link_val_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (next_pc_o == RESET_PC) && !link_en_o && (link_val_o == '0));

    // R3
    eq_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr_i[31:26]) == 6'd4 && $past(rs_val_i) == $past(rt_val_i))
        |-> next_pc_o == $past(pc_i) + 32'd4 +
            {{14{$past(instr_i[15])}}, $past(instr_i[15:0]), 2'b00});

    // R5
    zero_link_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr_i[31:26]) == 6'd1 &&
         ($past(instr_i[20:16]) == 5'd16 || $past(instr_i[20:16]) == 5'd17))
        |-> link_en_o && link_idx_o == LINK_IDX && link_val_o == $past(pc_i) + 32'd4);

    // R6
    seg_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr_i[31:26]) == 6'd2)
        |-> next_pc_o[27:0] == {$past(instr_i[25:0]), 2'b00} && !link_en_o);

    // R8
    reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr_i[31:26]) == 6'd0 && $past(instr_i[5:0]) == 6'd8)
        |-> next_pc_o == $past(rs_val_i) && !link_en_o);

    // R9
    quiet_link_chk: assert property (@(posedge clk) disable iff (rst)
        !link_en_o |-> link_idx_o == '0 && link_val_o == '0);
endmodule

bind nxpc_unit nxpc_unit_chk #(.RESET_PC(RESET_PC), .LINK_IDX(LINK_IDX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_i       (pc_i),
    .instr_i    (instr_i),
    .rs_val_i   (rs_val_i),
    .rt_val_i   (rt_val_i),
    .next_pc_o  (next_pc_o),
    .link_en_o  (link_en_o),
    .link_idx_o (link_idx_o),
    .link_val_o (link_val_o)
);

// File: tb/nxpc_unit_tb.sv
module nxpc_unit_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [31:0] RST_PC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic [31:0] next_pc_o;
    logic        link_en_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_val_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] npc;
        logic        len;
        logic [4:0]  idx;
        logic [31:0] lval;
    } exp_t;

    always #2.5 clk = ~clk;

    nxpc_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .pc_i       (pc_i),
        .instr_i    (instr_i),
        .rs_val_i   (rs_val_i),
        .rt_val_i   (rt_val_i),
        .next_pc_o  (next_pc_o),
        .link_en_o  (link_en_o),
        .link_idx_o (link_idx_o),
        .link_val_o (link_val_o)
    );

    function automatic exp_t model(input logic [31:0] pc, input logic [31:0] ins,
                                   input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        logic [31:0] p4  = pc + 32'd4;
        logic [31:0] rel = p4 + {{14{ins[15]}}, ins[15:0], 2'b00};
        logic [31:0] seg = {p4[31:28], ins[25:0], 2'b00};
        logic signed [31:0] sa = a;
        e.npc = p4; e.len = 0; e.idx = 0; e.lval = 0;
        case (ins[31:26])
            6'd0: if (ins[5:0] == 6'd8) e.npc = a;
            6'd1: case (ins[20:16])
                5'd0:  if (sa < 0)  e.npc = rel;
                5'd1:  if (sa >= 0) e.npc = rel;
                5'd16: begin if (sa < 0)  e.npc = rel; e.len = 1; end
                5'd17: begin if (sa >= 0) e.npc = rel; e.len = 1; end
                default: ;
            endcase
            6'd2: e.npc = seg;
            6'd3: begin e.npc = seg; e.len = 1; end
            6'd4: if (a == b) e.npc = rel;
            6'd5: if (a != b) e.npc = rel;
            6'd6: if (sa <= 0) e.npc = rel;
            6'd7: if (sa > 0)  e.npc = rel;
            default: ;
        endcase
        if (e.len) begin e.idx = 5'd31; e.lval = p4; end
        return e;
    endfunction

    function automatic string tag_of(input logic [31:0] ins);
        case (ins[31:26])
            6'd0: return (ins[5:0] == 6'd8) ? "R8" : "R2";
            6'd1: case (ins[20:16])
                5'd0, 5'd1:   return "R4";
                5'd16, 5'd17: return "R5";
                default:      return "R2";
            endcase
            6'd2: return "R6";
            6'd3: return "R7";
            6'd4, 6'd5: return "R3";
            6'd6, 6'd7: return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic run(input string req, input logic [31:0] pc, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        e = model(pc, ins, a, b);
        @(negedge clk);
        pc_i = pc; instr_i = ins; rs_val_i = a; rt_val_i = b;
        @(posedge clk);
        #1;
        chk(req, "next_pc", next_pc_o, e.npc);
        chk(req, "link_en", {31'd0, link_en_o}, {31'd0, e.len});
        chk(req, "link_idx", {27'd0, link_idx_o}, {27'd0, e.idx});
        chk(req, "link_val", link_val_o, e.lval);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    function automatic logic [31:0] pick_val(input logic [31:0] other);
        case ($urandom_range(0, 5))
            0: return other;
            1: return 32'd0;
            2: return 32'h8000_0000;
            3: return 32'd1;
            4: return 32'hFFFF_FFFF;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        #700000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0141));
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "next_pc", next_pc_o, RST_PC);
        chk("R1", "link_en", {31'd0, link_en_o}, 32'd0);
        chk("R1", "link_val", link_val_o, 32'd0);
        @(negedge clk);
        rst = 0;

        // directed corners
        run("R2", 32'h0000_2000, 32'h0000_0020, 32'd5, 32'd6);
        run("R3", 32'h0000_3000, {6'd4, 5'd1, 5'd2, 16'h0010}, 32'd7, 32'd7);
        run("R3", 32'h0000_3000, {6'd5, 5'd1, 5'd2, 16'h0010}, 32'd7, 32'd7);
        run("R10", 32'h0000_4000, {6'd4, 5'd1, 5'd2, 16'hFFFF}, 32'd9, 32'd9);
        run("R10", 32'hFFFF_FFFC, 32'h0000_0000, 32'd0, 32'd0);
        run("R4", 32'h100, {6'd6, 5'd3, 5'd0, 16'h0008}, 32'd0, 32'd0);
        run("R4", 32'h100, {6'd7, 5'd3, 5'd0, 16'h0008}, 32'd0, 32'd0);
        run("R4", 32'h100, {6'd1, 5'd3, 5'd0, 16'h0008}, 32'h8000_0000, 32'd0);
        run("R4", 32'h100, {6'd1, 5'd3, 5'd1, 16'h0008}, 32'd0, 32'd0);
        run("R5", 32'h200, {6'd1, 5'd3, 5'd16, 16'h0040}, 32'd4, 32'd0);
        run("R5", 32'h200, {6'd1, 5'd3, 5'd17, 16'hFFF0}, 32'd0, 32'd0);
        run("R2", 32'h200, {6'd1, 5'd3, 5'd5, 16'h0040}, 32'hFFFF_FFFF, 32'd0);
        run("R6", 32'hAFFF_FFFC, {6'd2, 26'h3FF_FFFF}, 32'd0, 32'd0);
        run("R6", 32'h7000_0010, {6'd2, 26'h000_0123}, 32'd0, 32'd0);
        run("R7", 32'h1234_5678, {6'd3, 26'h2AA_AAAA}, 32'd0, 32'd0);
        run("R8", 32'h500, {6'd0, 5'd31, 15'd0, 6'd8}, 32'h0000_0A0B, 32'd0);

        // R9: inputs changed after a negedge do not reach the outputs before the edge
        run("R9", 32'h600, {6'd0, 5'd31, 15'd0, 6'd8}, 32'h0000_7770, 32'd0);
        @(negedge clk);
        pc_i = 32'h900; instr_i = {6'd3, 26'h11}; rs_val_i = 0; rt_val_i = 0;
        #1;
        chk("R9", "next_pc held", next_pc_o, 32'h0000_7770);
        chk("R9", "link_en held", {31'd0, link_en_o}, 32'd0);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] ins;
            logic [31:0] a;
            logic [31:0] b;
            logic [5:0]  op;
            int sel = $urandom_range(0, 9);
            ins = $urandom();
            if (sel <= 7) op = 6'(sel);
            else if (sel == 8) op = 6'($urandom_range(8, 63));
            else op = 6'd0;
            ins[31:26] = op;
            if (sel == 9) ins[5:0] = 6'd8;
            if (op == 6'd1) begin
                case ($urandom_range(0, 4))
                    0: ins[20:16] = 5'd0;
                    1: ins[20:16] = 5'd1;
                    2: ins[20:16] = 5'd16;
                    3: ins[20:16] = 5'd17;
                    default: ;
                endcase
            end
            b = $urandom();
            a = pick_val(b);
            run(tag_of(ins), $urandom(), ins, a, b);
        end

        report();
        $finish;
    end
endmodule